// File: doc/BRIEF.md
# Serial Bus Inter-Frame Timer

This block listens to a single-wire serial bus and times how long the bus stays passive. The bus input is first synchronized to the local clock. A counter then advances once per microsecond tick for as long as the bus is passive. Three nested thresholds turn that count into events: the data portion of a message has ended (200 µs), the frame is complete (280 µs), and the inter-frame separation has elapsed (300 µs).

The block gives a one-cycle pulse for each of the first two thresholds and keeps a sticky copy of the frame-complete event, which software clears explicitly. A local transmit request is held back until the separation has fully elapsed and is then granted with a single pulse. If the bus turns active while the node is still waiting out the separation, the block treats this as another node's start of frame, signals it, and restarts its timing from that edge. A request that loses in this way is granted only after the next full separation. Bit encoding, arbitration and byte framing belong to other blocks.

Top module: `ift_timer`

## Requirements
- R1: While reset is low every output is low. After reset the synchronizer holds the passive level, so with a passive bus and a tick every cycle bus_idle first goes high on the 300th rising clock edge after reset is released.
- R2: bus_in is 1 for active and 0 for passive. With a tick every cycle, eod_pulse is high for exactly one cycle, after the 202nd rising edge that follows bus_in going passive (two synchronizer stages plus 200 counts).
- R3: Under the same conditions eof_pulse is high for exactly one cycle, after the 282nd rising edge.
- R4: eof_sticky rises on the edge after eof_pulse and stays high until eof_clr is sampled high.
- R5: The passive counter advances only on edges where tick_1us is high. Without ticks no threshold is reached. Once ticks resume, counting continues from the stored value.
- R6: Any active level on the synchronized bus clears the passive count. A gap that is interrupted reaches none of its later thresholds, and the next gap is timed again from zero.
- R7: The count saturates at 300 µs. During an arbitrarily long passive period eod_pulse and eof_pulse each fire exactly once, and bus_idle stays high.
- R8: bus_idle is high exactly when the separation has elapsed and the synchronized bus is passive. It falls on the second rising edge after bus_in goes active.
- R9: tx_grant is a one-cycle pulse on the edge after tx_req is sampled high while bus_idle is high. It fires at most once per passive gap, and a request raised while the bus is already idle is granted one edge later.
- R10: A passive-to-active edge of the synchronized bus seen while the count is between 280 and 299 produces a one-cycle early_sof pulse, three rising edges after bus_in goes active. An edge at any other count produces no early_sof pulse.
- R11: A request that is pending when an early edge occurs gets no grant during that frame. It is granted only after the following gap reaches a full separation, on the 303rd edge after bus_in goes passive again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1us | input | 1 | One-cycle enable each microsecond |
| bus_in | input | 1 | Raw bus level, 1 = active, 0 = passive |
| tx_req | input | 1 | Local request to start a frame |
| eof_clr | input | 1 | Clears eof_sticky |
| eod_pulse | output | 1 | End-of-data threshold reached |
| eof_pulse | output | 1 | End-of-frame threshold reached |
| eof_sticky | output | 1 | Held copy of eof_pulse |
| early_sof | output | 1 | Another node started a frame during the separation window |
| tx_grant | output | 1 | One-cycle permission to start a frame |
| bus_idle | output | 1 | Separation elapsed and bus passive |

## Verification
The timing is tried on an uninterrupted long passive gap, a gap broken off before end of frame, a gap with ticks withheld, and a gap broken off inside the separation window. Together these tell apart the exact threshold edges, clearing on activity, tick gating and saturation. Active edges inside and outside the 280–299 window show whether the early-start detection is correctly bounded. Requests held across an early edge, and requests raised after the bus is already idle, separate a correctly withheld grant from a lost or duplicated one.

// File: rtl/ift_pkg.sv
// Package: shared types for the inter-frame timer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package ift_pkg;

    // Phase of the current passive gap, decoded from the passive count
    typedef enum logic [1:0] {
        GAP_RUNNING   = 2'd0,
        GAP_DATA_END  = 2'd1,
        GAP_FRAME_END = 2'd2,
        GAP_SEP_DONE  = 2'd3
    } gap_phase_e;

endpackage

// File: rtl/ift_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes: the input is a slow level; RST_VAL is the safe (passive) level.
module ift_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the level one stage closer to the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= RST_VAL;
                else if (s == 0)
                    chain[s] <= d_async;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ift_gap_counter.sv
// Module: passive-gap counter with three nested threshold decodes.
// Assumes: EOD_US < EOF_US < SEP_US; bus_act is already synchronized.
// The count clears on any active level and saturates at SEP_US.
module ift_gap_counter
    import ift_pkg::*;
#(
    parameter int EOD_US = 200,
    parameter int EOF_US = 280,
    parameter int SEP_US = 300,
    parameter int CNT_W  = $clog2(SEP_US + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bus_act,
    output gap_phase_e phase,
    output logic       eod_hit,
    output logic       eof_hit
);
    localparam logic [CNT_W-1:0] EOD_LAST = CNT_W'(EOD_US - 1);
    localparam logic [CNT_W-1:0] EOF_LAST = CNT_W'(EOF_US - 1);
    localparam logic [CNT_W-1:0] EOD_C    = CNT_W'(EOD_US);
    localparam logic [CNT_W-1:0] EOF_C    = CNT_W'(EOF_US);
    localparam logic [CNT_W-1:0] SEP_C    = CNT_W'(SEP_US);

    logic [CNT_W-1:0] cnt;
    logic             inc;

    // Advance only on a tick, while passive, and below saturation
    assign inc = tick && !bus_act && (cnt != SEP_C);

    // Passive-duration count
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (bus_act)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    // One pulse per gap as the count steps onto each threshold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eod_hit <= 1'b0;
            eof_hit <= 1'b0;
        end else begin
            eod_hit <= inc && (cnt == EOD_LAST);
            eof_hit <= inc && (cnt == EOF_LAST);
        end
    end

    // Decode the current phase of the gap
    always_comb begin
        if (cnt == SEP_C)
            phase = GAP_SEP_DONE;
        else if (cnt >= EOF_C)
            phase = GAP_FRAME_END;
        else if (cnt >= EOD_C)
            phase = GAP_DATA_END;
        else
            phase = GAP_RUNNING;
    end
endmodule

// File: rtl/ift_edge_watch.sv
// Module: flags a passive-to-active bus edge seen inside the separation window.
// Assumes: in_window is evaluated from the count before it is cleared.
module ift_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_act,
    input  logic in_window,
    output logic early_sof
);
    logic bus_prev;

    // Remember last synchronized level and flag early rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_prev  <= 1'b0;
            early_sof <= 1'b0;
        end else begin
            bus_prev  <= bus_act;
            early_sof <= bus_act && !bus_prev && in_window;
        end
    end
endmodule

// File: rtl/ift_tx_gate.sv
// Module: grants a held transmit request once per completed separation.
// Assumes: bus_idle already combines separation-done with a passive bus.
module ift_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic bus_idle,
    input  logic bus_act,
    output logic tx_grant
);
    logic granted;
    logic grant_now;

    assign grant_now = tx_req && bus_idle && !granted;

    // Single grant per gap; activity re-arms the gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted  <= 1'b0;
            tx_grant <= 1'b0;
        end else begin
            tx_grant <= grant_now;
            if (bus_act)
                granted <= 1'b0;
            else if (grant_now)
                granted <= 1'b1;
        end
    end
endmodule

// File: rtl/ift_timer.sv
// Module: top of the inter-frame timer.
// Assumes: bus_in is asynchronous, 1 = active; tick_1us is a one-cycle pulse.
// Times passive gaps, flags data/frame end, gates transmit starts and
// resynchronizes to early starts by other nodes.
module ift_timer
    import ift_pkg::*;
#(
    parameter int EOD_US      = 200,
    parameter int EOF_US      = 280,
    parameter int SEP_US      = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1us,
    input  logic bus_in,
    input  logic tx_req,
    input  logic eof_clr,
    output logic eod_pulse,
    output logic eof_pulse,
    output logic eof_sticky,
    output logic early_sof,
    output logic tx_grant,
    output logic bus_idle
);
    localparam int CNT_W = $clog2(SEP_US + 1);

    logic       bus_act;
    gap_phase_e phase;

    ift_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_in),
        .q_sync  (bus_act)
    );

    ift_gap_counter #(
        .EOD_US(EOD_US), .EOF_US(EOF_US), .SEP_US(SEP_US), .CNT_W(CNT_W)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1us),
        .bus_act (bus_act),
        .phase   (phase),
        .eod_hit (eod_pulse),
        .eof_hit (eof_pulse)
    );

    ift_edge_watch u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_act   (bus_act),
        .in_window (phase == GAP_FRAME_END),
        .early_sof (early_sof)
    );

    // Separation elapsed and bus still passive
    assign bus_idle = (phase == GAP_SEP_DONE) && !bus_act;

    ift_tx_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (tx_req),
        .bus_idle (bus_idle),
        .bus_act  (bus_act),
        .tx_grant (tx_grant)
    );

    // Held end-of-frame flag; a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            eof_sticky <= 1'b0;
        else if (eof_pulse)
            eof_sticky <= 1'b1;
        else if (eof_clr)
            eof_sticky <= 1'b0;
    end
endmodule

// File: rtl/ift_timer_chk.sv
// Module: property checker for ift_timer, attached by bind below.
// Assumes: observes top-level ports plus the synchronized bus level.
module ift_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_act,
    input logic tx_req,
    input logic eod_pulse,
    input logic eof_pulse,
    input logic eof_sticky,
    input logic early_sof,
    input logic tx_grant,
    input logic bus_idle
);
    p_eod_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eod_pulse |=> !eod_pulse);

    p_eof_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> !eof_pulse);

    p_sticky_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eof_pulse |=> eof_sticky);

    p_idle_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_idle) && !bus_act) |-> bus_idle);

    p_idle_passive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |-> !bus_idle);

    p_grant_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> !tx_grant);

    p_grant_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> ($past(bus_idle) && $past(tx_req)));

    p_pulses_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eod_pulse, eof_pulse, early_sof, tx_grant}));
endmodule

bind ift_timer ift_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_act    (bus_act),
    .tx_req     (tx_req),
    .eod_pulse  (eod_pulse),
    .eof_pulse  (eof_pulse),
    .eof_sticky (eof_sticky),
    .early_sof  (early_sof),
    .tx_grant   (tx_grant),
    .bus_idle   (bus_idle)
);

// File: tb/tb_ift_timer.sv
// Directed bench for ift_timer: one task per scenario, each checking itself.
module tb_ift_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1us = 1'b1;
    logic bus_in = 1'b1;
    logic tx_req = 1'b0;
    logic eof_clr = 1'b0;
    logic eod_pulse, eof_pulse, eof_sticky, early_sof, tx_grant, bus_idle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Observation record for the last watch window (edge index, 0 = never)
    int eod_at, eod_cnt, eof_at, eof_cnt, early_at, early_cnt;
    int grant_at, grant_cnt, idle_at, idle_cnt, idle_off_at;

    ift_timer dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .bus_in(bus_in),
        .tx_req(tx_req), .eof_clr(eof_clr), .eod_pulse(eod_pulse),
        .eof_pulse(eof_pulse), .eof_sticky(eof_sticky), .early_sof(early_sof),
        .tx_grant(tx_grant), .bus_idle(bus_idle)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Count n rising edges, sampling at each following falling edge
    task automatic watch(input int n);
        eod_at = 0; eod_cnt = 0; eof_at = 0; eof_cnt = 0;
        early_at = 0; early_cnt = 0; grant_at = 0; grant_cnt = 0;
        idle_at = 0; idle_cnt = 0; idle_off_at = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (eod_pulse) begin eod_cnt++; if (eod_at == 0) eod_at = k; end
            if (eof_pulse) begin eof_cnt++; if (eof_at == 0) eof_at = k; end
            if (early_sof) begin early_cnt++; if (early_at == 0) early_at = k; end
            if (tx_grant) begin grant_cnt++; if (grant_at == 0) grant_at = k; end
            if (bus_idle) begin idle_cnt++; if (idle_at == 0) idle_at = k; end
            else if (idle_off_at == 0) idle_off_at = k;
        end
    endtask

    task automatic t_reset;
        bus_in = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1", "outputs in reset",
            int'({eod_pulse, eof_pulse, eof_sticky, early_sof, tx_grant, bus_idle}), 0);
        rst_n = 1'b1;
        watch(310);
        chk("R1", "idle edge after reset", idle_at, 300);
        chk("R1", "eod edge after reset", eod_at, 200);
    endtask

    task automatic t_thresholds;
        bus_in = 1'b1; watch(5);
        bus_in = 1'b0; watch(290);
        chk("R2", "eod edge", eod_at, 202);
        chk("R2", "eod count", eod_cnt, 1);
        chk("R3", "eof edge", eof_at, 282);
        chk("R3", "eof count", eof_cnt, 1);
        chk("R4", "sticky after eof", int'(eof_sticky), 1);
        eof_clr = 1'b1; @(negedge clk); eof_clr = 1'b0; @(negedge clk);
        chk("R4", "sticky after clear", int'(eof_sticky), 0);
    endtask

    task automatic t_no_tick;
        bus_in = 1'b1; watch(5);
        tick_1us = 1'b0;
        bus_in = 1'b0; watch(400);
        chk("R5", "eod without ticks", eod_cnt, 0);
        chk("R5", "idle without ticks", idle_cnt, 0);
        tick_1us = 1'b1; watch(210);
        chk("R5", "eod once ticks resume", eod_at, 200);
    endtask

    task automatic t_interrupt;
        bus_in = 1'b1; watch(5);
        bus_in = 1'b0; watch(250);
        chk("R6", "eof in broken gap", eof_cnt, 0);
        bus_in = 1'b1; watch(6);
        chk("R10", "early edge outside window", early_cnt, 0);
        bus_in = 1'b0; watch(290);
        chk("R6", "eod after restart", eod_at, 202);
        chk("R6", "eof after restart", eof_at, 282);
    endtask

    task automatic t_long_gap;
        bus_in = 1'b1; watch(5);
        bus_in = 1'b0; watch(600);
        chk("R7", "eod count long gap", eod_cnt, 1);
        chk("R7", "eof count long gap", eof_cnt, 1);
        chk("R8", "idle edge", idle_at, 302);
        chk("R7", "idle cycles held", idle_cnt, 299);
        bus_in = 1'b1; watch(4);
        chk("R8", "idle drop edge", idle_off_at, 2);
    endtask

    task automatic t_grant;
        bus_in = 1'b1; watch(5);
        tx_req = 1'b1;
        bus_in = 1'b0; watch(320);
        chk("R9", "grant edge held req", grant_at, 303);
        chk("R9", "grants per gap", grant_cnt, 1);
        tx_req = 1'b0;
        bus_in = 1'b1; watch(5);
        bus_in = 1'b0; watch(310);
        chk("R9", "no grant without req", grant_cnt, 0);
        tx_req = 1'b1; watch(5);
        chk("R9", "late req grant edge", grant_at, 1);
        chk("R9", "late req grant count", grant_cnt, 1);
        tx_req = 1'b0;
    endtask

    task automatic t_early_edge;
        bus_in = 1'b1; watch(5);
        tx_req = 1'b1;
        bus_in = 1'b0; watch(290);
        chk("R3", "eof before early edge", eof_at, 282);
        bus_in = 1'b1; watch(6);
        chk("R10", "early_sof edge", early_at, 3);
        chk("R10", "early_sof count", early_cnt, 1);
        chk("R11", "no grant on early edge", grant_cnt, 0);
        bus_in = 1'b0; watch(310);
        chk("R11", "grant after next gap", grant_at, 303);
        tx_req = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_thresholds();
        t_no_tick();
        t_interrupt();
        t_long_gap();
        t_grant();
        t_early_edge();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule